// File: doc/BRIEF.md
# SPI Master Shift Engine with Word FIFOs

This block is the serial heart of an SPI master. Words to send are queued in an eight-entry transmit FIFO. Each entry carries a data word and an end-of-transfer marker. A one-cycle start command makes the engine pull words from that FIFO and shift them out on `mosi`. At the same time it assembles incoming bits into words and queues them in an eight-entry receive FIFO. The serial clock rate is set outside the block. An external divider supplies `sclk_tick`, a single-cycle strobe, and every strobe moves `sck` by one half period.

Each word is 4 to 24 bits long and is sent MSB-first or LSB-first. The clock can idle low or high. The sampling edge is selectable. A loopback option feeds the outgoing bit stream back into the receive path. Three sticky events are kept: transfer done, receive overflow and transmit underflow. Each event has a mask bit, each is cleared by writing one, and any event that is set and not masked drives `irq`. Each FIFO has its own flush command, and a flush reports itself busy for exactly one cycle.

The controller is a three-state machine:
- ST_IDLE: the clock is parked at its idle level.
- ST_LEAD: waiting for the strobe that makes the leading clock edge.
- ST_TRAIL: waiting for the strobe that makes the trailing clock edge.

The transitions are:
- *launch* (ST_IDLE→ST_LEAD) on `start`.
- *lead edge* (ST_LEAD→ST_TRAIL) on a strobe.
- *next bit* (ST_TRAIL→ST_LEAD) on a strobe that does not end the transfer.
- *finish* (ST_TRAIL→ST_IDLE) on the strobe that ends the final bit of a word carrying the end marker.

Top module: `spi_eng`

## Requirements
- R1: Each word puts exactly the configured number of bits on `mosi`, between 4 and 24. A written length below 4 is taken as 4, and a length above 24 is taken as 24. With `cfg_lsb`=0 bit len-1 goes first; with `cfg_lsb`=1 bit 0 goes first.
- R2: `sck` rests at `cfg_cpol` while idle. With `cfg_cpha`=0, data is sampled on the leading edge (the edge away from the idle level) and advances on the trailing edge. With `cfg_cpha`=1, data advances on the leading edge and is sampled on the trailing edge.
- R3: After the final bit of a word pushed with `tx_last`=1, the engine returns to idle, `busy` drops, and event bit 0 (done) is set.
- R4: A `start` pulse while idle begins shifting from the transmit FIFO. Strobes received while idle leave `sck` and `busy` unchanged.
- R5: Each completed word is pushed into the receive FIFO, masked to the word length. With `cfg_loop`=1 the bits come from the outgoing stream; otherwise they come from `miso`.
- R6: When a word completes while the receive FIFO is full, the word is dropped, the FIFO contents are kept, and event bit 1 (receive overflow) is set.
- R7: When a new word is needed and the transmit FIFO is empty, event bit 2 (transmit underflow) is set. An all-zero word is then shifted and the transfer continues.
- R8: `tx_full` is high exactly when 8 words are queued for transmit. `rx_empty` is high exactly when the receive FIFO holds no word.
- R9: A `flush_tx` or `flush_rx` pulse sets `flush_busy[0]` or `flush_busy[1]` respectively for one cycle, after which that FIFO is empty.
- R10: Events are sticky and are cleared by writing one to `evt_clr`. `irq` is high exactly when some event is set with its `evt_mask` bit at 0.
- R11: A `cfg_wr` while `busy` is high has no effect on length, polarity, phase, order or loopback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_tick | input | 1 | Half-period strobe from the external clock divider |
| cfg_wr | input | 1 | Load the configuration fields below |
| cfg_len | input | 5 | Word length in bits (clamped to 4..24) |
| cfg_cpol | input | 1 | Idle level of `sck` |
| cfg_cpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| cfg_lsb | input | 1 | 1: least significant bit first |
| cfg_loop | input | 1 | 1: receive path takes the outgoing bit stream |
| start | input | 1 | Begin a transfer (ignored while busy) |
| flush_tx | input | 1 | Empty the transmit FIFO |
| flush_rx | input | 1 | Empty the receive FIFO |
| flush_busy | output | 2 | Flush in progress: bit 0 transmit, bit 1 receive |
| tx_push | input | 1 | Queue `tx_data` / `tx_last` |
| tx_data | input | 24 | Word to send |
| tx_last | input | 1 | Marks the final word of a transfer |
| tx_full | output | 1 | Transmit FIFO holds 8 words |
| rx_pop | input | 1 | Remove the head of the receive FIFO |
| rx_data | output | 24 | Head of the receive FIFO |
| rx_empty | output | 1 | Receive FIFO is empty |
| evt_mask | input | 3 | Per-event mask, 1 = masked |
| evt_clr | input | 3 | Write-one-to-clear for the events |
| events | output | 3 | Bit 0 done, bit 1 receive overflow, bit 2 transmit underflow |
| irq | output | 1 | Any unmasked event set |
| busy | output | 1 | Transfer in progress |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The main sweep runs two-word transfers for every word length from 4 to 24. It covers both polarities, both phases, both bit orders, and both the loopback and external receive paths. The bench holds `miso` at the inverse of `mosi`. Received words are therefore the complement of the sent words on the external path and equal to them in loopback, which shows which source the receive path used. Bits are captured at the edge the chosen phase calls for. A phase or bit-order error therefore shows up as a misplaced bit, and a length error shows up as a wrong bit count. Directed runs cover the following cases:
- a full receive FIFO followed by one more word;
- a transmit FIFO that runs dry between words;
- flushes;
- a configuration write during a transfer;
- a length below range;
- mask and clear combinations on `irq`.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

    localparam int LEN_W = 5;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_TRAIL
    } eng_state_e;

    localparam int EVT_DONE  = 0;
    localparam int EVT_RXOVF = 1;
    localparam int EVT_TXUDF = 2;
    localparam int EVT_N     = 3;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic             cpol;
        logic             cpha;
        logic             lsb;
        logic             loopb;
    } eng_cfg_t;

endpackage

// File: rtl/spi_eng_fifo.sv
module spi_eng_fifo #(
    parameter int W     = 25,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [AW:0]   cnt_q;
    logic          do_push, do_pop;

    assign full    = (cnt_q == (AW+1)'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full && !clr;
    assign do_pop  = pop && !empty && !clr;
    assign dout    = mem[rp_q];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp_q] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else if (clr) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
            if (do_pop)  rp_q <= (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
            cnt_q <= cnt_q + (AW+1)'(do_push) - (AW+1)'(do_pop);
        end
    end
endmodule

// File: rtl/spi_eng_core.sv
module spi_eng_core
    import spi_eng_pkg::*;
#(
    parameter int MAX_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start,
    input  eng_cfg_t         cfg,
    input  logic             miso,
    input  logic [MAX_W-1:0] tx_word,
    input  logic             tx_last,
    input  logic             tx_empty,
    input  logic             rx_full,
    output logic             tx_pop,
    output logic             rx_push,
    output logic [MAX_W-1:0] rx_word,
    output logic             sck,
    output logic             mosi,
    output logic             busy,
    output logic             ev_done,
    output logic             ev_ovf,
    output logic             ev_udf
);
    localparam int CW = $clog2(MAX_W + 1);

    eng_state_e       state_q, state_d;
    logic [MAX_W-1:0] sh_q, rx_q, rx_ins, sh_adv, lenmask;
    logic [MAX_W:0]   m_ext;
    logic [CW-1:0]    bit_q;
    logic             last_q, din, word_end, load_now;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_comb begin
        m_ext   = ({{MAX_W{1'b0}}, 1'b1} << cfg.len) - 1'b1;
        lenmask = m_ext[MAX_W-1:0];
        mosi    = cfg.lsb ? sh_q[0] : sh_q[cfg.len - 1'b1];
        din     = cfg.loopb ? mosi : miso;
        sh_adv  = cfg.lsb ? (sh_q >> 1) : (sh_q << 1);
        if (cfg.lsb) begin
            rx_ins = rx_q >> 1;
            rx_ins[cfg.len - 1'b1] = din;
        end else begin
            rx_ins = {rx_q[MAX_W-2:0], din};
        end
        word_end = (state_q == ST_TRAIL) && tick && (bit_q == CW'(cfg.len - 1'b1));
        load_now = ((state_q == ST_IDLE) && start) || (word_end && !last_q);
        tx_pop   = load_now && !tx_empty;
        ev_udf   = load_now && tx_empty;
        ev_done  = word_end && last_q;
        rx_push  = word_end && !rx_full;
        ev_ovf   = word_end && rx_full;
        rx_word  = (cfg.cpha ? rx_ins : rx_q) & lenmask;
        sck      = cfg.cpol ^ (state_q == ST_TRAIL);
        busy     = (state_q != ST_IDLE);

        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_LEAD;
            ST_LEAD:  if (tick)  state_d = ST_TRAIL;
            ST_TRAIL: if (tick)  state_d = (word_end && last_q) ? ST_IDLE : ST_LEAD;
            default:             state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            rx_q   <= '0;
            bit_q  <= '0;
            last_q <= 1'b0;
        end else begin
            if ((state_q == ST_LEAD) && tick) begin
                if (!cfg.cpha)          rx_q <= rx_ins;
                else if (bit_q != '0)   sh_q <= sh_adv;
            end
            if ((state_q == ST_TRAIL) && tick) begin
                if (cfg.cpha) rx_q <= rx_ins;
                if (!word_end) begin
                    bit_q <= bit_q + 1'b1;
                    if (!cfg.cpha) sh_q <= sh_adv;
                end
            end
            if (load_now) begin
                sh_q   <= tx_empty ? '0 : tx_word;
                last_q <= !tx_empty && tx_last;
                bit_q  <= '0;
            end
        end
    end
endmodule

// File: rtl/spi_eng.sv
module spi_eng
    import spi_eng_pkg::*;
#(
    parameter int MAX_W = 24,
    parameter int MIN_W = 4,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_tick,
    input  logic             cfg_wr,
    input  logic [4:0]       cfg_len,
    input  logic             cfg_cpol,
    input  logic             cfg_cpha,
    input  logic             cfg_lsb,
    input  logic             cfg_loop,
    input  logic             start,
    input  logic             flush_tx,
    input  logic             flush_rx,
    output logic [1:0]       flush_busy,
    input  logic             tx_push,
    input  logic [MAX_W-1:0] tx_data,
    input  logic             tx_last,
    output logic             tx_full,
    input  logic             rx_pop,
    output logic [MAX_W-1:0] rx_data,
    output logic             rx_empty,
    input  logic [2:0]       evt_mask,
    input  logic [2:0]       evt_clr,
    output logic [2:0]       events,
    output logic             irq,
    output logic             busy,
    output logic             sck,
    output logic             mosi,
    input  logic             miso
);
    eng_cfg_t         cfg_q;
    logic [LEN_W-1:0] len_clamped;
    logic [1:0]       flush_q;
    logic [EVT_N-1:0] evt_q, evt_set;
    logic             tx_empty, rx_full, tx_pop, rx_push, tx_last_h;
    logic             ev_done, ev_ovf, ev_udf;
    logic [MAX_W-1:0] tx_word, rx_word;

    always_comb begin
        if (cfg_len < LEN_W'(MIN_W))      len_clamped = LEN_W'(MIN_W);
        else if (cfg_len > LEN_W'(MAX_W)) len_clamped = LEN_W'(MAX_W);
        else                              len_clamped = cfg_len;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q   <= '{len: LEN_W'(8), cpol: 1'b0, cpha: 1'b0, lsb: 1'b0, loopb: 1'b0};
            flush_q <= '0;
            evt_q   <= '0;
        end else begin
            if (cfg_wr && !busy)
                cfg_q <= '{len: len_clamped, cpol: cfg_cpol, cpha: cfg_cpha,
                           lsb: cfg_lsb, loopb: cfg_loop};
            flush_q <= {flush_rx, flush_tx};
            evt_q   <= (evt_q & ~evt_clr) | evt_set;
        end
    end

    always_comb begin
        evt_set            = '0;
        evt_set[EVT_DONE]  = ev_done;
        evt_set[EVT_RXOVF] = ev_ovf;
        evt_set[EVT_TXUDF] = ev_udf;
    end

    assign flush_busy = flush_q;
    assign events     = evt_q;
    assign irq        = |(evt_q & ~evt_mask);

    spi_eng_fifo #(.W(MAX_W + 1), .DEPTH(DEPTH)) tx_fifo_i (
        .clk(clk), .rst_n(rst_n), .clr(flush_q[0]),
        .push(tx_push), .din({tx_last, tx_data}),
        .pop(tx_pop), .dout({tx_last_h, tx_word}),
        .full(tx_full), .empty(tx_empty)
    );

    spi_eng_fifo #(.W(MAX_W), .DEPTH(DEPTH)) rx_fifo_i (
        .clk(clk), .rst_n(rst_n), .clr(flush_q[1]),
        .push(rx_push), .din(rx_word),
        .pop(rx_pop), .dout(rx_data),
        .full(rx_full), .empty(rx_empty)
    );

    spi_eng_core #(.MAX_W(MAX_W)) core_i (
        .clk(clk), .rst_n(rst_n), .tick(sclk_tick), .start(start),
        .cfg(cfg_q), .miso(miso),
        .tx_word(tx_word), .tx_last(tx_last_h), .tx_empty(tx_empty),
        .rx_full(rx_full), .tx_pop(tx_pop), .rx_push(rx_push),
        .rx_word(rx_word), .sck(sck), .mosi(mosi), .busy(busy),
        .ev_done(ev_done), .ev_ovf(ev_ovf), .ev_udf(ev_udf)
    );
endmodule

// File: rtl/spi_eng_chk.sv
module spi_eng_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       start,
    input logic       sck,
    input logic       cpol,
    input logic [8:0] cfg_bits,
    input logic       core_done,
    input logic       core_ovf,
    input logic       rx_full,
    input logic [1:0] flush_busy,
    input logic       rx_empty,
    input logic [2:0] events,
    input logic       irq
);
    assert_sck_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sck == cpol));

    assert_cfg_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cfg_bits));

    assert_done_stops_R3: assert property (@(posedge clk) disable iff (!rst_n)
        core_done |=> !busy);

    assert_ovf_when_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        core_ovf |-> rx_full);

    assert_rx_flush_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_busy[1] |=> rx_empty);

    assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (events == 3'b000) |-> !irq);

    assert_idle_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> !busy);
endmodule

bind spi_eng spi_eng_chk chk_i (
    .clk(clk), .rst_n(rst_n), .busy(busy), .start(start), .sck(sck),
    .cpol(cfg_q.cpol), .cfg_bits(cfg_q), .core_done(ev_done),
    .core_ovf(ev_ovf), .rx_full(rx_full), .flush_busy(flush_busy),
    .rx_empty(rx_empty), .events(events), .irq(irq)
);

// File: tb/spi_eng_tb_top.sv
module spi_eng_tb_top;
    localparam int W = 24;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, sclk_tick, cfg_wr, cfg_cpol, cfg_cpha, cfg_lsb, cfg_loop;
    logic [4:0] cfg_len;
    logic start, flush_tx, flush_rx, tx_push, tx_last, rx_pop;
    logic [1:0] flush_busy;
    logic [W-1:0] tx_data, rx_data;
    logic tx_full, rx_empty, irq, busy, sck, mosi, miso;
    logic [2:0] evt_mask, evt_clr, events;

    assign miso = ~mosi;

    spi_eng #(.MAX_W(W), .MIN_W(4), .DEPTH(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .sclk_tick(sclk_tick), .cfg_wr(cfg_wr),
        .cfg_len(cfg_len), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .cfg_lsb(cfg_lsb), .cfg_loop(cfg_loop), .start(start),
        .flush_tx(flush_tx), .flush_rx(flush_rx), .flush_busy(flush_busy),
        .tx_push(tx_push), .tx_data(tx_data), .tx_last(tx_last),
        .tx_full(tx_full), .rx_pop(rx_pop), .rx_data(rx_data),
        .rx_empty(rx_empty), .evt_mask(evt_mask), .evt_clr(evt_clr),
        .events(events), .irq(irq), .busy(busy), .sck(sck), .mosi(mosi),
        .miso(miso)
    );

    int n_chk = 0, n_bad = 0;
    int cur_len = 8, cur_cpol = 0, cur_cpha = 0, cur_lsb = 0, cur_loop = 0;
    int exp_w [0:15];
    int n_w;
    logic mon [0:255];
    int mon_n = 0;
    logic mon_clr = 1'b0, sck_prev = 1'b0, mosi_prev = 1'b0;

    // edge capture of the serial stream at the sampling edge
    always @(negedge clk) begin
        if (mon_clr) mon_n <= 0;
        else if (sck != sck_prev && ((sck != cur_cpol[0]) == (cur_cpha == 0))) begin
            if (mon_n < 256) mon[mon_n] <= mosi_prev;
            mon_n <= mon_n + 1;
        end
        sck_prev  <= sck;
        mosi_prev <= mosi;
    end

    initial begin
        sclk_tick = 1'b0;
        forever begin
            repeat (2) @(negedge clk);
            sclk_tick = 1'b1;
            @(negedge clk);
            sclk_tick = 1'b0;
        end
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        summary();
        $finish;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int lmask(input int len);
        return (len >= 32) ? -1 : ((1 << len) - 1);
    endfunction

    function automatic int wgen(input int i, input int len);
        return ((i * 32'h9E3779B1) ^ (i << 7)) & lmask(len);
    endfunction

    task automatic setcfg(input int len, input int cpol, input int cpha,
                          input int lsb, input int loopb, input int eff_len);
        @(negedge clk);
        cfg_len = 5'(len); cfg_cpol = cpol[0]; cfg_cpha = cpha[0];
        cfg_lsb = lsb[0];  cfg_loop = loopb[0]; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        cur_len = eff_len; cur_cpol = cpol; cur_cpha = cpha;
        cur_lsb = lsb; cur_loop = loopb;
    endtask

    task automatic push(input int d, input bit last);
        @(negedge clk);
        tx_data = d[W-1:0]; tx_last = last; tx_push = 1'b1;
        @(negedge clk);
        tx_push = 1'b0; tx_last = 1'b0;
    endtask

    task automatic go();
        @(negedge clk); mon_clr = 1'b1;
        @(negedge clk); mon_clr = 1'b0; start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_idle();
        for (int t = 0; t < 20000 && busy; t++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic clr_evt();
        @(negedge clk); evt_clr = 3'b111;
        @(negedge clk); evt_clr = 3'b000;
    endtask

    task automatic check_bits(input string req);
        int bad = 0;
        if (mon_n != n_w * cur_len) bad++;
        else
            for (int k = 0; k < n_w; k++)
                for (int j = 0; j < cur_len; j++) begin
                    logic e;
                    e = cur_lsb ? exp_w[k][j] : exp_w[k][cur_len-1-j];
                    if (mon[k*cur_len + j] !== e) bad++;
                end
        chk(bad == 0, req, mon_n, n_w * cur_len);
    endtask

    task automatic pop_chk(input int sent, input string req);
        int e;
        e = cur_loop ? sent : (~sent & lmask(cur_len));
        chk(!rx_empty && rx_data == e[W-1:0], req, int'(rx_data), e);
        @(negedge clk); rx_pop = 1'b1;
        @(negedge clk); rx_pop = 1'b0;
    endtask

    initial begin
        int seed = 1;
        rst_n = 1'b0; cfg_wr = 1'b0; cfg_len = 5'd8; cfg_cpol = 1'b0;
        cfg_cpha = 1'b0; cfg_lsb = 1'b0; cfg_loop = 1'b0; start = 1'b0;
        flush_tx = 1'b0; flush_rx = 1'b0; tx_push = 1'b0; tx_data = '0;
        tx_last = 1'b0; rx_pop = 1'b0; evt_mask = 3'b000; evt_clr = 3'b000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (12) @(negedge clk);

        // reset state; strobes while idle do nothing (R4)
        chk(busy == 0 && sck == 0, "R4 idle after reset", {busy, sck}, 0);
        chk(tx_full == 0 && rx_empty == 1, "R8 reset status", {tx_full, rx_empty}, 1);
        chk(events == 0 && irq == 0, "R10 reset events", {events, irq}, 0);

        // sweep: every length, polarity, phase, order, receive source
        for (int lp = 0; lp < 2; lp++)
        for (int ls = 0; ls < 2; ls++)
        for (int ph = 0; ph < 2; ph++)
        for (int po = 0; po < 2; po++)
        for (int len = 4; len <= 24; len++) begin
            setcfg(len, po, ph, ls, lp, len);
            n_w = 2;
            exp_w[0] = wgen(seed, len); exp_w[1] = wgen(seed + 1, len);
            seed += 2;
            push(exp_w[0], 1'b0);
            push(exp_w[1], 1'b1);
            go();
            wait_idle();
            check_bits("R1 R2 bit stream");
            chk(events == 3'b001 && busy == 0, "R3 done event", {events, busy}, 2);
            chk(sck == po[0], "R2 idle level", sck, po);
            pop_chk(exp_w[0], "R5 rx word0");
            pop_chk(exp_w[1], "R5 rx word1");
            clr_evt();
        end

        // irq masking and write-one-to-clear (R10)
        setcfg(8, 0, 0, 0, 1, 8);
        n_w = 1; exp_w[0] = 8'h5A;
        push(exp_w[0], 1'b1); go(); wait_idle();
        pop_chk(exp_w[0], "R5 loopback");
        evt_mask = 3'b111; @(negedge clk);
        chk(irq == 0, "R10 masked", irq, 0);
        evt_mask = 3'b110; @(negedge clk);
        chk(irq == 1, "R10 unmasked", irq, 1);
        @(negedge clk); evt_clr = 3'b001;
        @(negedge clk); evt_clr = 3'b000;
        chk(events == 0 && irq == 0, "R10 cleared", {events, irq}, 0);
        evt_mask = 3'b000;

        // receive overflow with full FIFO (R6), status flags (R8)
        n_w = 8;
        for (int i = 0; i < 8; i++) begin
            exp_w[i] = wgen(100 + i, 8);
            push(exp_w[i], i == 7);
            if (i == 6) chk(tx_full == 0, "R8 seven queued", tx_full, 0);
        end
        chk(tx_full == 1, "R8 eight queued", tx_full, 1);
        go(); wait_idle();
        chk(events == 3'b001, "R6 no overflow yet", events, 1);
        n_w = 1; exp_w[8] = 8'hC3;
        push(8'hC3, 1'b1); go(); wait_idle();
        chk(events[1] == 1, "R6 overflow event", events, 3);
        for (int i = 0; i < 8; i++) pop_chk(exp_w[i], "R6 kept words");
        chk(rx_empty == 1, "R8 rx drained", rx_empty, 1);
        clr_evt();

        // transmit underflow shifts zeros and continues (R7)
        n_w = 3; exp_w[0] = 8'hA7; exp_w[1] = 0; exp_w[2] = 8'h3C;
        push(exp_w[0], 1'b0); go();
        for (int t = 0; t < 2000 && !events[2]; t++) @(negedge clk);
        push(exp_w[2], 1'b1);
        wait_idle();
        chk(events == 3'b101, "R7 underflow event", events, 5);
        check_bits("R7 zero word stream");
        for (int i = 0; i < 3; i++) pop_chk(exp_w[i], "R7 rx words");
        clr_evt();

        // flushes (R9)
        for (int i = 0; i < 3; i++) push(i + 1, 1'b0);
        @(negedge clk); flush_tx = 1'b1;
        @(negedge clk); flush_tx = 1'b0;
        chk(flush_busy == 2'b01, "R9 tx flush busy", flush_busy, 1);
        @(negedge clk);
        chk(flush_busy == 2'b00, "R9 tx flush done", flush_busy, 0);
        for (int i = 0; i < 7; i++) push(i, 1'b0);
        chk(tx_full == 0, "R9 tx emptied", tx_full, 0);
        push(7, 1'b1);
        chk(tx_full == 1, "R9 tx refilled", tx_full, 1);
        go(); wait_idle();
        chk(rx_empty == 0, "R5 rx filled", rx_empty, 0);
        @(negedge clk); flush_rx = 1'b1;
        @(negedge clk); flush_rx = 1'b0;
        chk(flush_busy == 2'b10, "R9 rx flush busy", flush_busy, 2);
        @(negedge clk);
        chk(flush_busy == 0 && rx_empty == 1, "R9 rx flushed", {flush_busy, rx_empty}, 1);
        clr_evt();

        // config write during a transfer is ignored (R11)
        n_w = 2; exp_w[0] = 8'h96; exp_w[1] = 8'h1E;
        push(exp_w[0], 1'b0); push(exp_w[1], 1'b1); go();
        repeat (10) @(negedge clk);
        cfg_len = 5'd4; cfg_cpol = 1'b1; cfg_cpha = 1'b1; cfg_loop = 1'b0; cfg_wr = 1'b1;
        @(negedge clk); cfg_wr = 1'b0;
        wait_idle();
        check_bits("R11 length and phase kept");
        chk(sck == 0, "R11 polarity kept", sck, 0);
        pop_chk(exp_w[0], "R11 loopback kept");
        pop_chk(exp_w[1], "R11 loopback kept");
        clr_evt();

        // length below range clamps to 4 (R1)
        setcfg(2, 1, 0, 0, 1, 4);
        chk(sck == 1, "R2 new idle level", sck, 1);
        n_w = 1; exp_w[0] = 4'h9;
        push(exp_w[0], 1'b1); go(); wait_idle();
        check_bits("R1 clamp to 4");
        pop_chk(exp_w[0], "R1 clamp rx");

        summary();
        $finish;
    end
endmodule